// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block accepts control words from a host microcontroller over a three-wire bus made of a bus clock, a serial data line and an enable line. The three bus lines are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. A rising bus-clock edge shifts one data bit into a staging shift register, but only while enable is high. Bus-clock edges that arrive while enable is low are ignored.

The staged word takes effect only when enable falls, and only if exactly the right number of bits arrived during that enable-high window. The mode input sets the word format. With the mode input high, a word is 18 bits long and carries a 14-bit divisor. With the mode input low, a word is 19 bits long and carries a 15-bit divisor. Four port bits always follow the divisor field. When a word is committed, the holding buffers drive the divisor output and four port-enable outputs. A port-enable output at 1 means that open-drain port is sinking. Any window with the wrong bit count leaves the buffers unchanged, so a host can abort a transfer by dropping enable early.

Top module: `tribus_ctrl_reg`

## Requirements
- R1: While reset is asserted, and after it is released, `divisor` is zero and all four `portOn` bits are 0 (off) until the first valid commit.
- R2: With `modeSel` high, a window of exactly 18 bits commits on the falling edge of enable. Bits are sampled on rising bus-clock edges, MSB first. `divisor[13:0]` takes the first 14 bits, `divisor[14]` is 0, and the last four bits go to `portOn[3:0]`, with the fourth-last bit in `portOn[3]` and the last bit in `portOn[0]`.
- R3: With `modeSel` low, a window of exactly 19 bits commits. `divisor[14:0]` takes the first 15 bits and `portOn[3:0]` takes the last four bits, in the same order as in R2.
- R4: Outputs do not change while bits are being shifted; they change only as a result of enable falling.
- R5: Bus-clock edges while enable is low neither shift data nor count toward the word length.
- R6: If the number of bits in an enable-high window differs from the word length of the current mode, `divisor` and `portOn` keep their previous values.
- R7: A bus-clock rising edge that reaches the synchronized domain in the same cycle as the enable falling edge is ignored. It neither counts as a bit nor shifts data.
- R8: A mode-high commit clears `divisor[14]`, even if the preceding mode-low word had set it.
- R9: After enable falls, the outputs still hold their old values after the second system-clock edge and show the new word after the third system-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busClk | input | 1 | Serial bus clock, asynchronous |
| busData | input | 1 | Serial bus data, asynchronous |
| busEn | input | 1 | Serial bus enable, asynchronous |
| modeSel | input | 1 | 1: 18-bit word with 14-bit divisor; 0: 19-bit word with 15-bit divisor |
| divisor | output | 15 | Committed divisor |
| portOn | output | 4 | Committed port enables, 1 = sinking |

## Verification
A bus-clock edge and the enable falling edge can be detected in the same system cycle, so a shift and a commit decision compete. The bench provokes this by raising the bus clock and lowering enable at the same instant after a complete 18-bit mode-high word. Both changes pass through identical synchronizers, so they arrive together. The result is judged by the outputs: they must show the 18-bit word. If the design had counted the extra edge, it would have seen 19 bits and kept the old values.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  // strobes from control to datapath, one system cycle wide
  typedef struct packed {
    logic shift;   // take one bit into the staging register
    logic commit;  // move the staged word into the holding buffers
  } strobe_t;
endpackage

// File: rtl/tribus_sync.sv
module tribus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[gi] <= '0;
          else       stage[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[gi] <= '0;
          else       stage[gi] <= stage[gi-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
#(
  parameter int DIV_SHORT = 14,
  parameter int DIV_LONG  = 15,
  parameter int PORT_W    = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkSync,
  input  logic    enSync,
  input  logic    modeSel,
  output strobe_t strb
);
  localparam int LEN_SHORT = DIV_SHORT + PORT_W;
  localparam int LEN_LONG  = DIV_LONG + PORT_W;
  localparam int CNT_MAX   = LEN_LONG + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic             prevClk;
  logic             prevEn;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] wordLen;
  logic             clkRise;
  logic             enFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevEn  <= 1'b0;
    end else begin
      prevClk <= clkSync;
      prevEn  <= enSync;
    end
  end

  assign clkRise = clkSync & ~prevClk;
  assign enFall  = ~enSync & prevEn;
  assign wordLen = modeSel ? CNT_W'(LEN_SHORT) : CNT_W'(LEN_LONG);

  // a clock edge is taken only while the synchronized enable is high,
  // so an edge that lands on the enable-fall cycle is dropped
  always_comb begin
    strb        = '0;
    strb.shift  = clkRise & enSync;
    strb.commit = enFall & (bitCnt == wordLen);
  end

  // counter saturates one above the longest word; cleared when a window closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    bitCnt <= '0;
    else if (enFall)                              bitCnt <= '0;
    else if (strb.shift && bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/tribus_dp.sv
module tribus_dp
  import tribus_pkg::*;
#(
  parameter int DIV_SHORT = 14,
  parameter int DIV_LONG  = 15,
  parameter int PORT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dataSync,
  input  logic                modeSel,
  input  strobe_t             strb,
  output logic [DIV_LONG-1:0] divisor,
  output logic [PORT_W-1:0]   portOn
);
  localparam int LEN_LONG = DIV_LONG + PORT_W;

  logic [LEN_LONG-1:0] shReg;
  logic [DIV_LONG-1:0] divShort;
  logic [DIV_LONG-1:0] divLong;
  logic [DIV_LONG-1:0] divNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.shift) shReg <= {shReg[LEN_LONG-2:0], dataSync};
  end

  // divisor field sits just above the port bits; short form is zero-extended
  always_comb begin
    divShort                = '0;
    divShort[DIV_SHORT-1:0] = shReg[DIV_SHORT+PORT_W-1:PORT_W];
    divLong                 = shReg[LEN_LONG-1:PORT_W];
    divNext                 = modeSel ? divShort : divLong;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
      portOn  <= '0;
    end else if (strb.commit) begin
      divisor <= divNext;
      portOn  <= shReg[PORT_W-1:0];
    end
  end
endmodule

// File: rtl/tribus_ctrl_reg.sv
module tribus_ctrl_reg
  import tribus_pkg::*;
#(
  parameter int DIV_SHORT   = 14,
  parameter int DIV_LONG    = 15,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busClk,
  input  logic                busData,
  input  logic                busEn,
  input  logic                modeSel,
  output logic [DIV_LONG-1:0] divisor,
  output logic [PORT_W-1:0]   portOn
);
  logic [2:0] busSync;
  strobe_t    strb;

  tribus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({busClk, busData, busEn}),
    .dout (busSync)
  );

  tribus_ctrl #(.DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG), .PORT_W(PORT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSync (busSync[2]),
    .enSync  (busSync[0]),
    .modeSel (modeSel),
    .strb    (strb)
  );

  tribus_dp #(.DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG), .PORT_W(PORT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataSync (busSync[1]),
    .modeSel  (modeSel),
    .strb     (strb),
    .divisor  (divisor),
    .portOn   (portOn)
  );
endmodule

// File: rtl/tribus_ctrl_reg_chk.sv
module tribus_ctrl_reg_chk #(
  parameter int DIV_LONG = 15,
  parameter int PORT_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busEn,
  input logic                modeSel,
  input logic [DIV_LONG-1:0] divisor,
  input logic [PORT_W-1:0]   portOn,
  input logic                shiftStb,
  input logic                commitStb
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> (divisor == '0 && portOn == '0)); // R1
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !commitStb |=> ($stable(divisor) && $stable(portOn))); // R4
  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    shiftStb |-> $past(busEn, 2)); // R5
  AST_COMMIT_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (!$past(busEn, 2) && $past(busEn, 3))); // R9
  AST_SHORT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && modeSel) |=> !divisor[DIV_LONG-1]); // R8
  AST_NO_SHIFT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !shiftStb); // R7
endmodule

bind tribus_ctrl_reg tribus_ctrl_reg_chk #(.DIV_LONG(DIV_LONG), .PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busEn     (busEn),
  .modeSel   (modeSel),
  .divisor   (divisor),
  .portOn    (portOn),
  .shiftStb  (strb.shift),
  .commitStb (strb.commit)
);

// File: tb/sim_tribus_ctrl_reg.sv
module sim_tribus_ctrl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busClk = 1'b0;
  logic        busData = 1'b0;
  logic        busEn = 1'b0;
  logic        modeSel = 1'b1;
  logic [14:0] divisor;
  logic [3:0]  portOn;

  int checks = 0;
  int fails  = 0;
  logic [14:0] expDiv  = '0;
  logic [3:0]  expPort = '0;

  always #4 clk = ~clk;

  tribus_ctrl_reg u0 (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busEn(busEn), .modeSel(modeSel), .divisor(divisor), .portOn(portOn)
  );

  // {mode, bit count, word}
  localparam int NVEC = 7;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 5'd18, 19'h2ABCD},  // R2 valid short word
    {1'b0, 5'd19, 19'h51234},  // R3 valid long word, top divisor bit set
    {1'b1, 5'd17, 19'h0F0F0},  // R6 too short
    {1'b0, 5'd18, 19'h3C3C3},  // R6 long mode with short count
    {1'b1, 5'd19, 19'h7FFFF},  // R6 short mode with long count
    {1'b1, 5'd18, 19'h3FFF0},  // R8 clears top bit
    {1'b0, 5'd19, 19'h7FFFF}   // R3 all ones
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model(input logic mode, input int n, input logic [18:0] word);
    if (n == (mode ? 18 : 19)) begin
      expDiv  = mode ? {1'b0, word[17:4]} : word[18:4];
      expPort = word[3:0];
    end
  endtask

  // sends n bits MSB first; coincide adds a clock rise on the enable-fall instant
  task automatic sendWord(input logic mode, input int n, input logic [18:0] word,
                          input bit coincide, input bit timed);
    logic [14:0] oldDiv;
    logic [14:0] midDiv;
    oldDiv = expDiv;
    modeSel = mode;
    waitCyc(1);
    busEn = 1'b1;
    waitCyc(4);
    for (int i = n - 1; i >= 0; i--) begin
      busData = word[i];
      waitCyc(4);
      busClk = 1'b1;
      waitCyc(4);
      busClk = 1'b0;
    end
    waitCyc(6);
    check("R4 hold divisor", 32'(divisor), 32'(expDiv));
    check("R4 hold ports", 32'(portOn), 32'(expPort));
    if (coincide) busClk = 1'b1;
    busEn = 1'b0;
    model(mode, n, word);
    repeat (2) @(posedge clk);
    @(negedge clk);
    midDiv = divisor;
    @(posedge clk);
    @(negedge clk);
    if (timed) begin
      check("R9 old after two edges", 32'(midDiv), 32'(oldDiv));
      check("R9 new after three edges", 32'(divisor), 32'(expDiv));
    end
    busClk = 1'b0;
    waitCyc(6);
  endtask

  initial begin
    waitCyc(3);
    check("R1 divisor in reset", 32'(divisor), 32'h0);
    check("R1 ports in reset", 32'(portOn), 32'h0);
    rstN = 1'b1;
    waitCyc(3);
    check("R1 divisor after reset", 32'(divisor), 32'h0);
    check("R1 ports after reset", 32'(portOn), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      sendWord(VEC[v][24], int'(VEC[v][23:19]), VEC[v][18:0], 1'b0, 1'b0);
      check($sformatf("R2/R3/R6/R8 vec%0d divisor", v), 32'(divisor), 32'(expDiv));
      check($sformatf("R2/R3/R6 vec%0d ports", v), 32'(portOn), 32'(expPort));
    end

    // R5: clock edges with enable low must not shift or count
    busData = 1'b1;
    for (int k = 0; k < 3; k++) begin
      waitCyc(4); busClk = 1'b1; waitCyc(4); busClk = 1'b0;
    end
    sendWord(1'b1, 18, 19'h15A5C, 1'b0, 1'b0);
    check("R5 divisor", 32'(divisor), 32'h15A5);
    check("R5 ports", 32'(portOn), 32'hC);

    // R7: clock rise landing with enable fall is ignored
    sendWord(1'b1, 18, 19'h0A5A3, 1'b1, 1'b0);
    check("R7 divisor", 32'(divisor), 32'h0A5A);
    check("R7 ports", 32'(portOn), 32'h3);

    // R9: commit latency
    sendWord(1'b0, 19, 19'h6DB6E, 1'b0, 1'b1);
    check("R3 long divisor", 32'(divisor), 32'h6DB6);
    check("R3 long ports", 32'(portOn), 32'hE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule